// File: doc/BRIEF.md
# Output Round and Limit Formatter

This block turns the wide signed result of a filter accumulator into a 16-bit output word. A 3-bit select sets where the word's effective LSB sits. The block adds half of that LSB and truncates, then clears every bit below the LSB. Results outside the allowed range are clamped. The allowed range is full scale, or half scale when the reduced-gain interpolation mode is active.

The clamped word is stored in a register. The register loads only on clock edges where the rate sequencer raises a capture strobe, which gives one load every other clock in decimation. The stored word is shown either in two's complement or in inverted offset binary. The bus is released to high impedance through an asynchronous active-low enable.

In `acc_i`, bit `GUARD_W` lines up with output bit 0. With the defaults (`ACC_W`=24, `GUARD_W`=4), the output value is therefore `acc_i`/16 before rounding.

Top module: `orl_top`

## Requirements
- R1: While `rst_ni` is low, the stored word is cleared to 0x0000. With `tc_fmt_i` high, `dout_o` then reads 0x0000.
- R2: For `rnd_sel_i` = k (0 to 7), the LSB of the word is at bit k, which is `acc_i` bit `GUARD_W`+k. The block adds one half of that LSB, truncates (a tie rounds toward plus infinity), and forces word bits below k to zero.
- R3: With `half_lim_i` low, a rounded value above 32767 gives 0x7FFF with bits below k cleared. A value below -32768 gives 0x8000. The clamp is applied after rounding, so a rounding carry that overflows also clamps.
- R4: With `half_lim_i` high, the limits are 0x3FFF (bits below k cleared) and 0xC000. Values inside these limits pass unchanged.
- R5: With `tc_fmt_i` high, `dout_o` shows the stored word in two's complement. With it low, bit 15 is kept and bits 14..0 are inverted (inverted offset binary). The format applies to the stored word without a clock.
- R6: With `oe_ni` high, all 16 bits of `dout_o` are high impedance. With `oe_ni` low, the word is driven. Neither change waits for a clock.
- R7: The stored word loads on a rising `clk_i` edge only when `cap_i` is high. Otherwise it holds, whatever `acc_i`, `rnd_sel_i` and `half_lim_i` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_i | input | ACC_W | Signed accumulator result |
| rnd_sel_i | input | 3 | Effective LSB position k |
| half_lim_i | input | 1 | Selects the half-scale limits |
| tc_fmt_i | input | 1 | 1: two's complement, 0: inverted offset binary |
| cap_i | input | 1 | Capture strobe from the rate sequencer |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| dout_o | output | 16 | Output word, tri-stated |

## Verification
Negative ties test the rounding direction: -1.5 LSB must give 0xFFFF. A design that rounds away from zero or truncates toward zero returns 0xFFFE or 0xFFFF at the wrong points.

An input of 7FFF.8 probes the order of rounding and clamping. A design that clamps before rounding wraps to 0x8000 instead of holding 0x7FFF. The masked maximum (0x7FF0 at k=4) catches a clamp that forgets the low-bit clear, and half mode catches limits that ignore the mode.

Inverted offset binary at reset (0x7FFF), tri-state release, and a hold when the strobe is idle expose coding errors, a registered enable, and an unconditional load.

// File: rtl/orl_pkg.sv
package orl_pkg;
  function automatic logic [15:0] lsb_clear_mask(input logic [2:0] k);
    lsb_clear_mask = ~((16'd1 << k) - 16'd1);
  endfunction
endpackage

// File: rtl/orl_round.sv
module orl_round #(
  parameter int ACC_W   = 24,
  parameter int GUARD_W = 4,
  parameter int SEL_W   = 3,
  localparam int SUM_W  = ACC_W + 1,
  localparam int VAL_W  = SUM_W - GUARD_W
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [VAL_W-1:0] val_o
);
  logic [SUM_W-1:0] half_lsb;
  logic [SUM_W-1:0] sum;

  always_comb begin
    half_lsb = {{(SUM_W-1){1'b0}}, 1'b1} << (GUARD_W - 1 + int'(sel_i));
    sum      = {acc_i[ACC_W-1], acc_i} + half_lsb;
    val_o    = sum[SUM_W-1:GUARD_W];
  end
endmodule

// File: rtl/orl_limit.sv
module orl_limit #(
  parameter int VAL_W = 21,
  parameter int OUT_W = 16,
  parameter int SEL_W = 3
) (
  input  logic [VAL_W-1:0] val_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             half_i,
  output logic [OUT_W-1:0] word_o
);
  import orl_pkg::*;
  localparam logic signed [VAL_W-1:0] FULL_MAX = VAL_W'((2**(OUT_W-1)) - 1);
  localparam logic signed [VAL_W-1:0] FULL_MIN = -FULL_MAX - 1;
  localparam logic signed [VAL_W-1:0] HALF_MAX = VAL_W'((2**(OUT_W-2)) - 1);
  localparam logic signed [VAL_W-1:0] HALF_MIN = -HALF_MAX - 1;

  logic signed [VAL_W-1:0] v, hi, lo;
  logic [OUT_W-1:0] mask, pre;

  always_comb begin
    v    = $signed(val_i);
    hi   = half_i ? HALF_MAX : FULL_MAX;
    lo   = half_i ? HALF_MIN : FULL_MIN;
    mask = lsb_clear_mask(sel_i);
    if (v > hi)      pre = hi[OUT_W-1:0];
    else if (v < lo) pre = lo[OUT_W-1:0];
    else             pre = v[OUT_W-1:0];
    word_o = pre & mask;
  end
endmodule

// File: rtl/orl_format.sv
module orl_format #(
  parameter int OUT_W = 16
) (
  input  logic [OUT_W-1:0] word_i,
  input  logic             tc_i,
  output logic [OUT_W-1:0] word_o
);
  assign word_o = tc_i ? word_i : {word_i[OUT_W-1], ~word_i[OUT_W-2:0]};

  // R5: sign position is never inverted
  always_comb a_r5_msb_kept: assert (word_o[OUT_W-1] == word_i[OUT_W-1]);
endmodule

// File: rtl/orl_top.sv
module orl_top #(
  parameter int ACC_W   = 24,
  parameter int GUARD_W = 4,
  localparam int OUT_W  = 16,
  localparam int SEL_W  = 3,
  localparam int VAL_W  = ACC_W + 1 - GUARD_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] acc_i,
  input  logic [SEL_W-1:0] rnd_sel_i,
  input  logic             half_lim_i,
  input  logic             tc_fmt_i,
  input  logic             cap_i,
  input  logic             oe_ni,
  output logic [OUT_W-1:0] dout_o
);
  import orl_pkg::*;

  logic [VAL_W-1:0] rounded;
  logic [OUT_W-1:0] limited, word_q, shown;

  orl_round #(.ACC_W(ACC_W), .GUARD_W(GUARD_W), .SEL_W(SEL_W)) u_round (
    .acc_i(acc_i), .sel_i(rnd_sel_i), .val_o(rounded)
  );

  orl_limit #(.VAL_W(VAL_W), .OUT_W(OUT_W), .SEL_W(SEL_W)) u_limit (
    .val_i(rounded), .sel_i(rnd_sel_i), .half_i(half_lim_i), .word_o(limited)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    word_q <= '0;
    else if (cap_i) word_q <= limited;
  end

  orl_format #(.OUT_W(OUT_W)) u_format (
    .word_i(word_q), .tc_i(tc_fmt_i), .word_o(shown)
  );

  assign dout_o = oe_ni ? 'z : shown;

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(word_q));
  a_r2_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> (word_q & ~lsb_clear_mask($past(rnd_sel_i))) == '0);
  a_r4_half_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && half_lim_i) |=> (word_q[15] == word_q[14]));
  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && !acc_i[ACC_W-1] && (acc_i[ACC_W-2:GUARD_W+OUT_W-1] != '0))
      |=> (word_q[15] == 1'b0));
endmodule

// File: tb/orl_top_tb.sv
module orl_top_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [23:0] acc = '0;
  logic [2:0]  sel = '0;
  logic        half = 0, tc = 1, cap = 0, oe_n = 0;
  wire  [15:0] dout;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  orl_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .acc_i(acc), .rnd_sel_i(sel),
    .half_lim_i(half), .tc_fmt_i(tc), .cap_i(cap), .oe_ni(oe_n), .dout_o(dout)
  );

  function automatic logic [15:0] model(logic [23:0] a, int k, bit h, bit t);
    longint v, r, hi, lo;
    logic [15:0] w;
    v  = longint'($signed(a));
    r  = (v + (longint'(1) <<< (3 + k))) >>> (4 + k);
    r  = r <<< k;
    hi = ((h ? 16383 : 32767) >> k) << k;
    lo = h ? -16384 : -32768;
    if (r > hi) r = hi;
    if (r < lo) r = lo;
    w = r[15:0];
    return t ? w : {w[15], ~w[14:0]};
  endfunction

  task automatic check(string req, logic [15:0] exp);
    checks++;
    if (dout !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, dout, exp);
    end
  endtask

  task automatic apply(logic [23:0] a, int k, bit h);
    @(negedge clk);
    acc = a; sel = 3'(k); half = h; cap = 1;
    @(negedge clk);
    cap = 0;
  endtask

  task automatic run(string req, logic [23:0] a, int k, bit h);
    apply(a, k, h);
    check(req, model(a, k, h, tc));
  endtask

  task automatic t_reset;
    #1;
    check("R1", 16'h0000);
    tc = 0; #1;
    check("R1/R5", 16'h7FFF);
    tc = 1;
  endtask

  task automatic t_round;
    run("R2", 24'h000128, 0, 0);
    run("R2", 24'hFFFFE8, 0, 0);
    check("R2", 16'hFFFF);
    run("R2", 24'h000640, 3, 0);
    for (int k = 0; k < 8; k++) run("R2", 24'h0ABCDE, k, 0);
    for (int k = 0; k < 8; k++) run("R2", 24'hF54321, k, 0);
  endtask

  task automatic t_sat;
    run("R3", 24'h7FFFF8, 0, 0);
    check("R3", 16'h7FFF);
    run("R3", 24'h7FFFF8, 4, 0);
    check("R3", 16'h7FF0);
    run("R3", 24'h07FFF8, 0, 0);
    check("R3", 16'h7FFF);
    run("R3", 24'h800000, 0, 0);
    check("R3", 16'h8000);
    run("R3", 24'h07FFF7, 0, 0);
    check("R3", 16'h7FFF);
  endtask

  task automatic t_half;
    run("R4", 24'h050000, 0, 1);
    check("R4", 16'h3FFF);
    run("R4", 24'hFA0000, 0, 1);
    check("R4", 16'hC000);
    run("R4", 24'h012340, 2, 1);
    run("R4", 24'h050000, 5, 1);
    check("R4", 16'h3FE0);
  endtask

  task automatic t_format;
    apply(24'h000130, 0, 0);
    tc = 0; #1;
    check("R5", 16'h7FEC);
    apply(24'hFFFF00, 0, 0);
    check("R5", model(24'hFFFF00, 0, 0, 0));
    tc = 1; #1;
    check("R5", 16'hFFF0);
  endtask

  task automatic t_oe;
    apply(24'h001230, 0, 0);
    #1 oe_n = 1; #1;
    check("R6", 16'hzzzz);
    oe_n = 0; #1;
    check("R6", 16'h0123);
  endtask

  task automatic t_hold;
    apply(24'h002220, 0, 0);
    acc = 24'h7FFFFF; sel = 3'd7; half = 1;
    repeat (3) @(negedge clk);
    check("R7", 16'h0222);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_round();
    t_sat();
    t_half();
    t_format();
    t_oe();
    t_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule